// File: doc/BRIEF.md
# System Clock Mode Register

This block holds the 8-bit mode register that picks the system clock source and divider. It turns the picked source into a one-cycle clock-enable pulse on a common fast clock. Two sources arrive as enable ticks on that clock: the external oscillator and the on-chip oscillator. The external source can be used undivided, divided by two or divided by eight. The same register also drives the stack page-select output and one stop control for each oscillator.

Software reaches the register through a plain write/read port at one fixed address. Two fields lock after the first write following reset: the two processor-mode bits and the oscillation-mode bit. Only a new reset makes them writable again. After reset the system runs from the on-chip oscillator. Software must wait for an oscillator to settle before switching to it, because the block does not handle settling time.

Top module: `ckm_top`

## Requirements
- R1: After reset, a read at address 0x3B returns 0x80, so the system runs from the on-chip oscillator and every other field is 0.
- R2: Bits 7:6 pick the clock source. With code 2'b10, sys_ce pulses in exactly the cycles in which ring_tick is high and on-chip oscillator stop (bit 4) is 0.
- R3: With code 2'b00, sys_ce pulses on every second counted osc_tick. An osc_tick is counted only while external oscillator stop (bit 3) is 0.
- R4: With code 2'b01, sys_ce pulses on every eighth counted osc_tick.
- R5: With code 2'b11 and ceramic mode (bit 5 = 0), sys_ce follows every counted osc_tick with no division.
- R6: With code 2'b11 and RC mode (bit 5 = 1), the divider works as with code 2'b00.
- R7: The first write to the register after reset sets bits 1:0 (processor mode) and bit 5 (oscillation mode). Later writes leave those bits unchanged until the next reset. The other bits stay writable.
- R8: stack_page follows bit 2, xosc_stop follows bit 3 and ring_stop follows bit 4. When a source is stopped it produces no sys_ce pulse.
- R9: A write that changes the effective division restarts the divider. With an osc_tick in every cycle after a switch to divide-by-eight, the first pulse comes in the eighth cycle after the write cycle.
- R10: A write to any address other than 0x3B leaves the register and every output unchanged.
- R11: bus_rdata gives the current register value, locked bits included, while bus_addr is 0x3B, and gives 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | External oscillator enable tick |
| ring_tick | input | 1 | On-chip oscillator enable tick |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| sys_ce | output | 1 | System clock-enable pulse |
| stack_page | output | 1 | Stack page select |
| xosc_stop | output | 1 | External oscillator stop request |
| ring_stop | output | 1 | On-chip oscillator stop request |

## Verification
A wrong register or lock state shows on bus_rdata in the cycle after the write. It also changes which ticks reach sys_ce, starting in that same next cycle. A divider counter that is off by even one count moves the next sys_ce pulse by at least one cycle. So comparing sys_ce against a reference in every cycle catches it within one division period, which is at most eight ticks. A missed restart shows up as an early first pulse after a change of division.

// File: rtl/ckm_pkg.sv
package ckm_pkg;

   typedef enum logic [1:0] {
      SEL_DIV_FAST = 2'b00,
      SEL_DIV_SLOW = 2'b01,
      SEL_RING     = 2'b10,
      SEL_DIRECT   = 2'b11
   } clk_sel_e;

   localparam int BIT_STACK  = 2;
   localparam int BIT_XSTOP  = 3;
   localparam int BIT_RSTOP  = 4;
   localparam int BIT_RCMODE = 5;
   localparam int BIT_SEL_LO = 6;

   // fields that accept a single write after reset
   localparam logic [7:0] ONCE_MASK = 8'b0010_0011;

   // undivided clocking is not allowed with RC oscillation: fall back to /2
   function automatic clk_sel_e resolve_sel(input logic [1:0] code, input logic rc);
      if (code == 2'b11 && rc)
         return SEL_DIV_FAST;
      return clk_sel_e'(code);
   endfunction

endpackage

// File: rtl/ckm_regfile.sv
module ckm_regfile
   import ckm_pkg::*;
#(
   parameter int         ADDR_W    = 8,
   parameter logic [7:0] REG_ADDR  = 8'h3B,
   parameter logic [7:0] RESET_VAL = 8'h80,
   parameter bit         ONE_SHOT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        mode_q,
   output logic [7:0]        mode_d,
   output logic              lock_q,
   output logic              wr_hit
);

   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

   assign wr_hit = bus_wr && (bus_addr == HIT_ADDR);

   generate
      if (ONE_SHOT) begin : g_lock
         logic lock_r;
         always_ff @(posedge clk) begin
            if (!rst_n)
               lock_r <= 1'b0;
            else if (wr_hit)
               lock_r <= 1'b1;
         end
         assign lock_q = lock_r;
      end else begin : g_nolock
         assign lock_q = 1'b0;
      end
   endgenerate

   always_comb begin
      mode_d = mode_q;
      if (wr_hit) begin
         if (lock_q)
            mode_d = (bus_wdata & ~ONCE_MASK) | (mode_q & ONCE_MASK);
         else
            mode_d = bus_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= RESET_VAL;
      else
         mode_q <= mode_d;
   end

endmodule

// File: rtl/ckm_srcsel.sv
module ckm_srcsel
   import ckm_pkg::*;
(
   input  logic [7:0] mode_q,
   input  logic [7:0] mode_d,
   output clk_sel_e   eff_sel,
   output logic       restart
);

   clk_sel_e next_sel;

   assign eff_sel  = resolve_sel(mode_q[BIT_SEL_LO +: 2], mode_q[BIT_RCMODE]);
   assign next_sel = resolve_sel(mode_d[BIT_SEL_LO +: 2], mode_d[BIT_RCMODE]);
   assign restart  = (next_sel != eff_sel);

endmodule

// File: rtl/ckm_divider.sv
module ckm_divider
   import ckm_pkg::*;
#(
   parameter int DIV_FAST = 2,
   parameter int DIV_SLOW = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  clk_sel_e sel,
   input  logic     restart,
   input  logic     osc_tick,
   input  logic     ring_tick,
   input  logic     xosc_stop,
   input  logic     ring_stop,
   output logic     sys_ce
);

   localparam int             CNT_W     = $clog2(DIV_SLOW);
   localparam logic [CNT_W-1:0] TERM_FAST = CNT_W'(DIV_FAST - 1);
   localparam logic [CNT_W-1:0] TERM_SLOW = CNT_W'(DIV_SLOW - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;
   logic             divided;
   logic             osc_ok;
   logic             ring_ok;

   assign osc_ok  = osc_tick && !xosc_stop;
   assign ring_ok = ring_tick && !ring_stop;
   assign divided = (sel == SEL_DIV_FAST) || (sel == SEL_DIV_SLOW);
   assign term    = (sel == SEL_DIV_SLOW) ? TERM_SLOW : TERM_FAST;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart || !divided)
         cnt_q <= '0;
      else if (osc_ok)
         cnt_q <= (cnt_q == term) ? '0 : cnt_q + 1'b1;
   end

   always_comb begin
      unique case (sel)
         SEL_RING:   sys_ce = ring_ok;
         SEL_DIRECT: sys_ce = osc_ok;
         default:    sys_ce = osc_ok && (cnt_q == term);
      endcase
   end

endmodule

// File: rtl/ckm_top.sv
module ckm_top
   import ckm_pkg::*;
#(
   parameter int         ADDR_W    = 8,
   parameter logic [7:0] REG_ADDR  = 8'h3B,
   parameter logic [7:0] RESET_VAL = 8'h80,
   parameter int         DIV_FAST  = 2,
   parameter int         DIV_SLOW  = 8,
   parameter bit         ONE_SHOT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic              ring_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              sys_ce,
   output logic              stack_page,
   output logic              xosc_stop,
   output logic              ring_stop
);

   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

   generate
      if (DIV_FAST < 2 || DIV_SLOW <= DIV_FAST) begin : g_bad_div
         $error("ckm_top: need 2 <= DIV_FAST < DIV_SLOW");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("ckm_top: ADDR_W out of range");
      end
   endgenerate

   logic [7:0] mode_q;
   logic [7:0] mode_d;
   logic       lock_q;
   logic       wr_hit;
   logic       restart;
   clk_sel_e   eff_sel;

   ckm_regfile #(
      .ADDR_W   (ADDR_W),
      .REG_ADDR (REG_ADDR),
      .RESET_VAL(RESET_VAL),
      .ONE_SHOT (ONE_SHOT)
   ) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .mode_q   (mode_q),
      .mode_d   (mode_d),
      .lock_q   (lock_q),
      .wr_hit   (wr_hit)
   );

   ckm_srcsel sel_i (
      .mode_q (mode_q),
      .mode_d (mode_d),
      .eff_sel(eff_sel),
      .restart(restart)
   );

   ckm_divider #(
      .DIV_FAST(DIV_FAST),
      .DIV_SLOW(DIV_SLOW)
   ) div_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (eff_sel),
      .restart  (restart),
      .osc_tick (osc_tick),
      .ring_tick(ring_tick),
      .xosc_stop(xosc_stop),
      .ring_stop(ring_stop),
      .sys_ce   (sys_ce)
   );

   assign stack_page = mode_q[BIT_STACK];
   assign xosc_stop  = mode_q[BIT_XSTOP];
   assign ring_stop  = mode_q[BIT_RSTOP];
   assign bus_rdata  = (bus_addr == HIT_ADDR) ? mode_q : 8'h00;

endmodule

// File: rtl/ckm_chk.sv
module ckm_chk
   import ckm_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       osc_tick,
   input logic       ring_tick,
   input logic       sys_ce,
   input logic       xosc_stop,
   input logic       ring_stop,
   input logic       wr_hit,
   input logic       lock_q,
   input logic [7:0] mode_q,
   input clk_sel_e   eff_sel
);

   // R2
   ring_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_ce && eff_sel == SEL_RING) |-> (ring_tick && !ring_stop));

   // R3
   osc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_ce && eff_sel != SEL_RING) |-> osc_tick);

   // R8
   xstop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xosc_stop && eff_sel != SEL_RING) |-> !sys_ce);

   // R7
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && wr_hit) |=> (mode_q[5] == $past(mode_q[5]) &&
                              mode_q[1:0] == $past(mode_q[1:0])));

   // R4
   slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_ce && eff_sel == SEL_DIV_SLOW && !wr_hit) |=> !sys_ce);

endmodule

bind ckm_top ckm_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .osc_tick (osc_tick),
   .ring_tick(ring_tick),
   .sys_ce   (sys_ce),
   .xosc_stop(xosc_stop),
   .ring_stop(ring_stop),
   .wr_hit   (wr_hit),
   .lock_q   (lock_q),
   .mode_q   (mode_q),
   .eff_sel  (eff_sel)
);

// File: tb/ckm_top_tb_top.sv
module ckm_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick = 1'b0;
   logic       ring_tick = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       sys_ce;
   logic       stack_page;
   logic       xosc_stop;
   logic       ring_stop;

   int n_chk = 0;
   int n_bad = 0;
   logic       last_ce;
   logic [7:0] last_rd;

   // reference state
   logic [7:0] m_reg;
   logic       m_lock;
   int         m_cnt;

   always #5 clk = ~clk;

   ckm_top dut_i (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ring_tick(ring_tick),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .sys_ce(sys_ce), .stack_page(stack_page),
      .xosc_stop(xosc_stop), .ring_stop(ring_stop)
   );

   function automatic logic [1:0] eff_code(input logic [7:0] r);
      return (r[7:6] == 2'b11 && r[5]) ? 2'b00 : r[7:6];
   endfunction

   function automatic int term_of(input logic [1:0] e);
      return (e == 2'b01) ? 7 : 1;
   endfunction

   function automatic logic exp_ce(input logic [7:0] r, input int cnt, input logic o, input logic g);
      case (eff_code(r))
         2'b10:   return g && !r[4];
         2'b11:   return o && !r[3];
         default: return o && !r[3] && (cnt == term_of(eff_code(r)));
      endcase
   endfunction

   function automatic string ce_tag(input logic [7:0] r);
      if (r[7:6] == 2'b11 && r[5]) return "R6";
      case (r[7:6])
         2'b00: return "R3";
         2'b01: return "R4";
         2'b10: return "R2";
         default: return "R5";
      endcase
   endfunction

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_reg  = 8'h80;
      m_lock = 1'b0;
      m_cnt  = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bus_wr = 1'b0; osc_tick = 1'b0; ring_tick = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic step(input logic wr, input logic [7:0] a, input logic [7:0] d,
                       input logic o, input logic g);
      logic [7:0] nreg;
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = d; osc_tick = o; ring_tick = g;
      #2;
      last_ce = sys_ce;
      last_rd = bus_rdata;
      check(ce_tag(m_reg), {7'd0, sys_ce}, {7'd0, exp_ce(m_reg, m_cnt, o, g)});
      check((a == 8'h3B) ? "R11" : "R10", bus_rdata, (a == 8'h3B) ? m_reg : 8'h00);
      check("R8", {5'd0, ring_stop, xosc_stop, stack_page}, {5'd0, m_reg[4], m_reg[3], m_reg[2]});
      @(posedge clk);
      #1;
      nreg = m_reg;
      if (wr && a == 8'h3B) begin
         nreg = m_lock ? ((d & ~8'h23) | (m_reg & 8'h23)) : d;
         m_lock = 1'b1;
      end
      if (eff_code(nreg) != eff_code(m_reg))
         m_cnt = 0;
      else if (eff_code(m_reg) == 2'b10 || eff_code(m_reg) == 2'b11)
         m_cnt = 0;
      else if (o && !m_reg[3])
         m_cnt = (m_cnt == term_of(eff_code(m_reg))) ? 0 : m_cnt + 1;
      m_reg = nreg;
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_C10C));
      model_reset();
      do_reset();

      // R1 reset value
      step(1'b0, 8'h3B, 8'h00, 1'b0, 1'b0);
      check("R1", last_rd, 8'h80);
      // R2 on-chip source
      step(1'b0, 8'h3B, 8'h00, 1'b0, 1'b1);
      check("R2", {7'd0, last_ce}, 8'h01);
      step(1'b0, 8'h3B, 8'h00, 1'b1, 1'b0);
      check("R2", {7'd0, last_ce}, 8'h00);

      // first write: /2, ceramic, pmode 00
      step(1'b1, 8'h3B, 8'h00, 1'b0, 1'b0);
      for (int k = 0; k < 6; k++) step(1'b0, 8'h3B, 8'h00, 1'b1, 1'b0);

      // R9: switch to /8, first pulse in 8th cycle after write
      step(1'b1, 8'h3B, 8'h40, 1'b1, 1'b0);
      for (int k = 1; k <= 8; k++) begin
         step(1'b0, 8'h3B, 8'h00, 1'b1, 1'b0);
         check("R9", {7'd0, last_ce}, {7'd0, (k == 8)});
      end

      // R7 locked fields keep their values
      step(1'b1, 8'h3B, 8'hE3, 1'b0, 1'b0);
      step(1'b0, 8'h3B, 8'h00, 1'b1, 1'b0);
      check("R7", last_rd, 8'hC0);
      check("R5", {7'd0, last_ce}, 8'h01);

      // R10 other address ignored
      step(1'b1, 8'h3A, 8'h00, 1'b1, 1'b0);
      step(1'b0, 8'h3B, 8'h00, 1'b0, 1'b0);
      check("R10", last_rd, 8'hC0);

      // R8 stack page and external stop
      step(1'b1, 8'h3B, 8'hCC, 1'b0, 1'b0);
      step(1'b0, 8'h3B, 8'h00, 1'b1, 1'b1);
      check("R8", {5'd0, ring_stop, xosc_stop, stack_page}, 8'h03);
      check("R8", {7'd0, last_ce}, 8'h00);
      step(1'b1, 8'h3B, 8'h90, 1'b0, 1'b0);
      step(1'b0, 8'h3B, 8'h00, 1'b0, 1'b1);
      check("R8", {7'd0, last_ce}, 8'h00);

      // R6 after reset: RC with undivided code acts as /2
      do_reset();
      step(1'b1, 8'h3B, 8'hE0, 1'b0, 1'b0);
      step(1'b0, 8'h3B, 8'h00, 1'b1, 1'b0);
      check("R6", {7'd0, last_ce}, 8'h00);
      check("R7", last_rd, 8'hE0);
      step(1'b0, 8'h3B, 8'h00, 1'b1, 1'b0);
      check("R6", {7'd0, last_ce}, 8'h01);

      // random phase
      for (int i = 0; i < 20000; i++) begin
         logic wr, o, g;
         logic [7:0] a, d;
         if ($urandom_range(0, 1999) == 0) do_reset();
         wr = ($urandom_range(0, 7) == 0);
         a  = ($urandom_range(0, 3) != 0) ? 8'h3B : 8'($urandom);
         d  = 8'($urandom);
         if ($urandom_range(0, 2) != 0) d[4:3] = 2'b00;
         o  = ($urandom_range(0, 3) != 0);
         g  = ($urandom_range(0, 1) != 0);
         step(wr, a, d, o, g);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule